// File: doc/BRIEF.md
# UART Interrupt Source Prioritizer and Identifier

This block sits beside a 16550-style serial port and turns its interrupt conditions into one request line and a 4-bit identification code. Five conditions are tracked. The first is a receiver line error. The second is the receive FIFO at or above its trigger level. The third is a receive timeout, raised after several idle character times. The fourth is the transmit holding register becoming empty. The fifth is a change on any modem status line. Each condition has its own enable. When several are pending at once, a fixed priority order chooses the one that is reported.

Each source is cleared by the register access that would service it. Reading the line status register clears the line error. The receive-data condition follows the FIFO level directly. Reading the receive buffer, or any FIFO activity, clears the timeout. Writing the transmit holding register clears transmit-empty. Reading the modem status register clears the modem source. The transmit-empty source can also be cleared by reading the identification register, but only when the code that read returned was transmit-empty. The surrounding port logic supplies the access strobes, the FIFO status and a tick once per character time.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and just after it is released, `iid_o` is 4'b0001 and `irq_o` is 0, and no source is pending.
- R2: When no enabled source is pending, `iid_o` is 4'b0001 and `irq_o` is 0. When any enabled source is pending, `irq_o` is 1 and `iid_o[0]` is 0.
- R3: Priority from highest to lowest: line error (0110), receive data (0100), receive timeout (1100), transmit empty (0010), modem status (0000).
- R4: A one-cycle pulse on `rx_line_err_i` latches the line-error source, which is reported from the next cycle. A pulse on `lsr_rd_i` clears it. If both occur in the same cycle, the set takes effect.
- R5: The receive-data source (0100) is reported in the same cycle that `rx_lvl_ge_trig_i` is 1, and is removed as soon as that input returns to 0.
- R6: In FIFO mode, with the FIFO non-empty, TO_CHARS (default 4) pulses of `char_tick_i` with no `rx_act_i` and no `rbr_rd_i` between them latch the timeout source. It is reported in the cycle after the last tick. Activity restarts the count from zero.
- R7: The timeout source is cleared, and its count restarted, by `rbr_rd_i`, by `rx_act_i`, by the FIFO being empty, or by `fifo_mode_i` being 0. Outside FIFO mode `iid_o[3]` is never 1.
- R8: A rising edge on `thr_empty_i` latches the transmit-empty source (0010). A `thr_wr_i` pulse clears it, and the clear wins over a set in the same cycle.
- R9: An identification read is the interval during which `iid_o` is read while `iir_rd_i` is high. The code is captured in the first cycle of that interval. When `iir_rd_i` falls, transmit-empty is cleared only if the captured code was 0010. A source of higher priority that arrives during the read changes neither outcome.
- R10: A 1 on any bit of `msr_delta_i` latches the modem source (0000). A `msr_rd_i` pulse clears it, and a change in the same cycle as the read keeps it pending.
- R11: The enable bits are: `en_i[0]` for receive data and timeout, `en_i[1]` for transmit empty, `en_i[2]` for line error, `en_i[3]` for modem status. A disabled source is neither reported nor able to raise `irq_o`. Its latched state is kept and appears as soon as the source is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 4 | Per-source enables (see R11) |
| fifo_mode_i | input | 1 | 1 when the FIFOs are in use |
| rx_lvl_ge_trig_i | input | 1 | Receive level at or above the trigger |
| rx_nonempty_i | input | 1 | Receive FIFO holds at least one character |
| rx_act_i | input | 1 | Pulse on a push into or pop from the receive FIFO |
| char_tick_i | input | 1 | One pulse per character time |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| rx_line_err_i | input | 1 | Line error event pulse |
| lsr_rd_i | input | 1 | Line status read strobe |
| thr_empty_i | input | 1 | Transmit holding register empty level |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read, high for the access |
| msr_delta_i | input | MS_W | Modem line change flags |
| msr_rd_i | input | 1 | Modem status read strobe |
| iid_o | output | 4 | Identification code |
| irq_o | output | 1 | Interrupt request |

## Verification
The priority encoder is tested with stacked patterns. Sources are added one above another, so each new code proves that the higher level overrides the lower one, and then removed one by one, so the code falls back through each level in turn. Enable masks are varied while sources are latched, which separates "not latched" from "latched but hidden". Timeout patterns place activity one tick before the limit, which separates a restarting counter from one that only pauses. Identification reads are run three ways: transmit-empty alone, a higher source arriving during the read, and a higher source already present when the read starts. Together these show whether the clear uses the captured code or the live one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NSRC = 5;

   // Index in the request vector equals priority rank (0 = highest).
   localparam int SRC_LS   = 0;
   localparam int SRC_RDA  = 1;
   localparam int SRC_TO   = 2;
   localparam int SRC_THRE = 3;
   localparam int SRC_MS   = 4;

   localparam logic [3:0] IID_NONE = 4'b0001;
   localparam logic [3:0] IID_LS   = 4'b0110;
   localparam logic [3:0] IID_RDA  = 4'b0100;
   localparam logic [3:0] IID_TO   = 4'b1100;
   localparam logic [3:0] IID_THRE = 4'b0010;
   localparam logic [3:0] IID_MS   = 4'b0000;

   function automatic logic [3:0] src_code(input int idx);
      case (idx)
         SRC_LS:   return IID_LS;
         SRC_RDA:  return IID_RDA;
         SRC_TO:   return IID_TO;
         SRC_THRE: return IID_THRE;
         SRC_MS:   return IID_MS;
         default:  return IID_NONE;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) flag_q <= 1'b0;
            else         flag_q <= set_i | (flag_q & ~clr_i);
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) flag_q <= 1'b0;
            else         flag_q <= ~clr_i & (set_i | flag_q);
         end
      end
   endgenerate

   assign flag_o = flag_q;

endmodule

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto #(
   parameter int TO_CHARS = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic enable_i,
   input  logic nonempty_i,
   input  logic act_i,
   input  logic rd_i,
   input  logic tick_i,
   output logic pend_o
);

   localparam int CW = (TO_CHARS > 1) ? $clog2(TO_CHARS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TO_CHARS - 1);

   generate
      if (TO_CHARS < 1) begin : g_bad_limit
         $error("uart_irq_rxto: TO_CHARS must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          pend_q;
   logic          restart;

   assign restart = ~enable_i | ~nonempty_i | act_i | rd_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (restart) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (tick_i && !pend_q) begin
         if (cnt_q == LAST) begin
            cnt_q  <= '0;
            pend_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/uart_irq_rdcap.sv
module uart_irq_rdcap #(
   parameter bit         CLR_ON_READ = 1'b1,
   parameter logic [3:0] MATCH       = 4'b0010
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       rd_i,
   input  logic [3:0] code_i,
   output logic       clr_o
);

   generate
      if (CLR_ON_READ) begin : g_cap
         logic rd_q;
         logic hit_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               rd_q  <= 1'b0;
               hit_q <= 1'b0;
            end else begin
               rd_q <= rd_i;
               if (rd_i && !rd_q) hit_q <= (code_i == MATCH);
            end
         end

         assign clr_o = rd_q & ~rd_i & hit_q;
      end else begin : g_nocap
         assign clr_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic [NSRC-1:0] req_i,
   output logic [3:0]      code_o
);

   always_comb begin
      code_o = IID_NONE;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i]) code_o = src_code(i);
      end
   end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int TO_CHARS     = 4,
   parameter int MS_W         = 4,
   parameter bit IIR_RD_CLEAR = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [3:0]      en_i,
   input  logic            fifo_mode_i,
   input  logic            rx_lvl_ge_trig_i,
   input  logic            rx_nonempty_i,
   input  logic            rx_act_i,
   input  logic            char_tick_i,
   input  logic            rbr_rd_i,
   input  logic            rx_line_err_i,
   input  logic            lsr_rd_i,
   input  logic            thr_empty_i,
   input  logic            thr_wr_i,
   input  logic            iir_rd_i,
   input  logic [MS_W-1:0] msr_delta_i,
   input  logic            msr_rd_i,
   output logic [3:0]      iid_o,
   output logic            irq_o
);

   generate
      if (MS_W < 1) begin : g_bad_ms
         $error("uart_irq_ident: MS_W must be at least 1");
      end
   endgenerate

   logic ls_pend, to_pend, thre_pend, ms_pend;
   logic thr_prev_q, thre_set, thre_clr, iir_clr;
   logic [NSRC-1:0] req;
   logic [3:0] code;

   uart_irq_flag #(.SET_WINS(1'b1)) u_ls (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(rx_line_err_i), .clr_i(lsr_rd_i), .flag_o(ls_pend)
   );

   uart_irq_rxto #(.TO_CHARS(TO_CHARS)) u_rxto (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .enable_i(fifo_mode_i), .nonempty_i(rx_nonempty_i),
      .act_i(rx_act_i), .rd_i(rbr_rd_i), .tick_i(char_tick_i),
      .pend_o(to_pend)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) thr_prev_q <= 1'b1;
      else         thr_prev_q <= thr_empty_i;
   end

   assign thre_set = thr_empty_i & ~thr_prev_q;
   assign thre_clr = thr_wr_i | iir_clr;

   uart_irq_rdcap #(.CLR_ON_READ(IIR_RD_CLEAR), .MATCH(IID_THRE)) u_rdcap (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .rd_i(iir_rd_i), .code_i(code), .clr_o(iir_clr)
   );

   uart_irq_flag #(.SET_WINS(1'b0)) u_thre (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(thre_set), .clr_i(thre_clr), .flag_o(thre_pend)
   );

   uart_irq_flag #(.SET_WINS(1'b1)) u_ms (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(|msr_delta_i), .clr_i(msr_rd_i), .flag_o(ms_pend)
   );

   assign req[SRC_LS]   = ls_pend & en_i[2];
   assign req[SRC_RDA]  = rx_lvl_ge_trig_i & en_i[0];
   assign req[SRC_TO]   = to_pend & en_i[0];
   assign req[SRC_THRE] = thre_pend & en_i[1];
   assign req[SRC_MS]   = ms_pend & en_i[3];

   uart_irq_prio u_prio (
      .req_i(req), .code_o(code)
   );

   assign iid_o = code;
   assign irq_o = |req;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int MS_W = 4
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [3:0]      en_i,
   input logic            fifo_mode_i,
   input logic            rx_act_i,
   input logic            rbr_rd_i,
   input logic            rx_line_err_i,
   input logic            thr_wr_i,
   input logic [MS_W-1:0] msr_delta_i,
   input logic            msr_rd_i,
   input logic [3:0]      iid_o,
   input logic            irq_o
);

   assert_idle_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !irq_o |-> iid_o == 4'b0001);

   assert_pending_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> !iid_o[0]);

   assert_ls_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_line_err_i && en_i[2]) |=> iid_o == 4'b0110);

   assert_to_act_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_act_i || rbr_rd_i) |=> iid_o != 4'b1100);

   assert_to_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fifo_mode_i |=> !iid_o[3]);

   assert_thr_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      thr_wr_i |=> iid_o != 4'b0010);

   assert_ms_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msr_rd_i && msr_delta_i == '0) |=> iid_o != 4'b0000);

   assert_masked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i == 4'b0000) |-> !irq_o);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.MS_W(MS_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .fifo_mode_i(fifo_mode_i),
   .rx_act_i(rx_act_i), .rbr_rd_i(rbr_rd_i), .rx_line_err_i(rx_line_err_i),
   .thr_wr_i(thr_wr_i), .msr_delta_i(msr_delta_i), .msr_rd_i(msr_rd_i),
   .iid_o(iid_o), .irq_o(irq_o)
);

// File: tb/uart_irq_ident_tb.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [3:0] en_i = 4'b1111;
   logic       fifo_mode_i = 1'b1;
   logic       rx_lvl_ge_trig_i = 1'b0;
   logic       rx_nonempty_i = 1'b0;
   logic       rx_act_i = 1'b0;
   logic       char_tick_i = 1'b0;
   logic       rbr_rd_i = 1'b0;
   logic       rx_line_err_i = 1'b0;
   logic       lsr_rd_i = 1'b0;
   logic       thr_empty_i = 1'b0;
   logic       thr_wr_i = 1'b0;
   logic       iir_rd_i = 1'b0;
   logic [3:0] msr_delta_i = 4'b0000;
   logic       msr_rd_i = 1'b0;
   logic [3:0] iid_o;
   logic       irq_o;

   int total = 0;
   int bad = 0;

   always #4 clk_i = ~clk_i;

   uart_irq_ident dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .fifo_mode_i(fifo_mode_i),
      .rx_lvl_ge_trig_i(rx_lvl_ge_trig_i), .rx_nonempty_i(rx_nonempty_i),
      .rx_act_i(rx_act_i), .char_tick_i(char_tick_i), .rbr_rd_i(rbr_rd_i),
      .rx_line_err_i(rx_line_err_i), .lsr_rd_i(lsr_rd_i),
      .thr_empty_i(thr_empty_i), .thr_wr_i(thr_wr_i), .iir_rd_i(iir_rd_i),
      .msr_delta_i(msr_delta_i), .msr_rd_i(msr_rd_i),
      .iid_o(iid_o), .irq_o(irq_o)
   );

   // en, lvl, lerr, lsrrd, delta, msrrd, thre, thrwr | exp iid, exp irq
   localparam int NVEC = 19;
   localparam logic [18:0] VEC [NVEC] = '{
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0100, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0010, 1'b1},
      {4'b1111, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0100, 1'b1},
      {4'b1111, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0110, 1'b1},
      {4'b1111, 1'b1, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0100, 1'b1},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0001, 1'b0},
      {4'b0000, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b0},
      {4'b1000, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b1},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b1},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0001, 1'b0},
      {4'b1011, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b0},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0110, 1'b1},
      {4'b1111, 1'b0, 1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0001, 1'b0},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b0},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0010, 1'b1},
      {4'b1111, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b1, 1'b1, 4'b0001, 1'b0}
   };
   localparam string VTAG [NVEC] = '{
      "R2", "R10", "R10", "R3", "R5", "R4", "R4", "R8", "R10", "R11",
      "R11", "R10", "R10", "R11", "R11", "R4", "R2", "R8", "R8"
   };

   task automatic cyc();
      @(posedge clk_i);
      @(negedge clk_i);
   endtask

   task automatic chk(input string req, input logic [3:0] exp_iid, input logic exp_irq);
      total++;
      if (iid_o !== exp_iid || irq_o !== exp_irq) begin
         bad++;
         $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b",
                  req, iid_o, irq_o, exp_iid, exp_irq);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         char_tick_i = 1'b1;
         cyc();
         char_tick_i = 1'b0;
         cyc();
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk_i);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk_i);
      chk("R1", 4'b0001, 1'b0);
      cyc();
      rst_ni = 1'b1;
      cyc();
      chk("R1", 4'b0001, 1'b0);

      for (int k = 0; k < NVEC; k++) begin
         en_i             = VEC[k][18:15];
         rx_lvl_ge_trig_i = VEC[k][14];
         rx_line_err_i    = VEC[k][13];
         lsr_rd_i         = VEC[k][12];
         msr_delta_i      = VEC[k][11:8];
         msr_rd_i         = VEC[k][7];
         thr_empty_i      = VEC[k][6];
         thr_wr_i         = VEC[k][5];
         cyc();
         chk(VTAG[k], VEC[k][4:1], VEC[k][0]);
      end
      en_i = 4'b1111; rx_lvl_ge_trig_i = 0; rx_line_err_i = 0; lsr_rd_i = 0;
      msr_delta_i = '0; msr_rd_i = 0; thr_wr_i = 0;
      cyc();

      // R9: plain identification read clears transmit-empty
      thr_empty_i = 0; cyc(); thr_empty_i = 1; cyc();
      chk("R8", 4'b0010, 1'b1);
      iir_rd_i = 1; cyc();
      chk("R9", 4'b0010, 1'b1);
      iir_rd_i = 0; cyc();
      chk("R9", 4'b0001, 1'b0);

      // R9: higher source arrives mid-read; transmit-empty still cleared
      thr_empty_i = 0; cyc(); thr_empty_i = 1; cyc();
      iir_rd_i = 1; cyc();
      rx_line_err_i = 1; cyc();
      chk("R3", 4'b0110, 1'b1);
      rx_line_err_i = 0; iir_rd_i = 0; cyc();
      lsr_rd_i = 1; cyc();
      chk("R9", 4'b0001, 1'b0);
      lsr_rd_i = 0;

      // R9: read returns line error; transmit-empty kept
      rx_line_err_i = 1; cyc();
      rx_line_err_i = 0; thr_empty_i = 0; cyc();
      thr_empty_i = 1; cyc();
      chk("R3", 4'b0110, 1'b1);
      iir_rd_i = 1; cyc();
      iir_rd_i = 0; cyc();
      lsr_rd_i = 1; cyc();
      chk("R9", 4'b0010, 1'b1);
      lsr_rd_i = 0; thr_wr_i = 1; cyc();
      chk("R8", 4'b0001, 1'b0);
      thr_wr_i = 0;

      // R6/R7: receive timeout
      rx_nonempty_i = 1; cyc();
      ticks(3);
      chk("R6", 4'b0001, 1'b0);
      ticks(1);
      chk("R6", 4'b1100, 1'b1);
      rx_lvl_ge_trig_i = 1; cyc();
      chk("R3", 4'b0100, 1'b1);
      rx_lvl_ge_trig_i = 0; rbr_rd_i = 1; cyc();
      chk("R7", 4'b0001, 1'b0);
      rbr_rd_i = 0;
      ticks(3);
      rx_act_i = 1; cyc(); rx_act_i = 0;
      ticks(3);
      chk("R6", 4'b0001, 1'b0);
      ticks(1);
      chk("R6", 4'b1100, 1'b1);
      rx_act_i = 1; cyc();
      chk("R7", 4'b0001, 1'b0);
      rx_act_i = 0;
      fifo_mode_i = 0;
      ticks(5);
      chk("R7", 4'b0001, 1'b0);
      fifo_mode_i = 1; rx_nonempty_i = 0;
      ticks(5);
      chk("R7", 4'b0001, 1'b0);

      // R1: reset with sources latched
      rx_line_err_i = 1; msr_delta_i = 4'b0001; cyc();
      rx_line_err_i = 0; msr_delta_i = '0;
      chk("R4", 4'b0110, 1'b1);
      rst_ni = 0; cyc();
      chk("R1", 4'b0001, 1'b0);
      rst_ni = 1; cyc();
      chk("R1", 4'b0001, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule